// File: doc/BRIEF.md
# Three-Pass Multi-Word Modular Subtractor

This block produces (a − b) mod n for operands that are stored as N words of W bits each, least significant word at address 0, in external operand banks. Rather than attempting the whole job in one address sweep, the controller issues three separate commands, one after another. Each command makes exactly one ascending pass over the word addresses.

The first pass (DIFF) forms a − b and keeps the final borrow in a flag. The second pass (WRAP) forms a − b + n. Both of these results go into an internal two-bank scratch store. The third pass (PICK) copies one of the two stored results to the output bank. It copies a − b when the kept borrow is clear and a − b + n when it is set.

A single pipelined word adder serves all the passes. It takes operands one cycle after the address is issued and produces its result two cycles later. The carry between words is held in a register, so each word adds in the carry left by the word below it. The block is correct only if 0 ≤ a, b < n.

Top module: `modsub_seq`

## Requirements
- R1: While reset is high and in the first cycle after it is released, `done`, `rd_en` and `wr_en` are low.
- R2: A `start` pulse in an idle cycle with `op` = 0 (DIFF), 1 (WRAP) or 2 (PICK) begins one sweep over addresses 0, 1, …, N−1, one address per cycle. The sweep begins in the next cycle. DIFF and WRAP present these addresses on `rd_addr` with `rd_en` high. PICK does not raise `rd_en`.
- R3: DIFF computes a − b word by word, least significant word first, into scratch bank 0. It sets the kept borrow exactly when a < b. It never raises `wr_en`.
- R4: WRAP computes a − b + n modulo 2^(W·N) into scratch bank 1. It leaves the kept borrow unchanged and never raises `wr_en`.
- R5: PICK writes N words to the output port at ascending addresses. It writes scratch bank 0 if the kept borrow is clear and scratch bank 1 if it is set. After DIFF, WRAP and PICK, the written value equals (a − b) mod n.
- R6: Operand words are taken from `a_word`, `b_word` and `n_word` one cycle after their address appears. For PICK, the first `wr_en` appears four cycles after the cycle in which `start` was sampled high.
- R7: `done` is a one-cycle pulse. It comes in the cycle right after the last write-stage cycle of the sweep, once per accepted command.
- R8: A `start` that arrives while a command is running is ignored. The running command finishes unchanged, and the ignored pulse produces no extra sweep or `done`.
- R9: A `start` with `op` = 3 is ignored. It produces no sweep, no write and no `done`.
- R10: The kept borrow holds its value from the end of DIFF until the next DIFF. Repeating PICK gives the same output again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command strobe |
| op | input | 2 | Command code: 0 DIFF, 1 WRAP, 2 PICK, 3 ignored |
| done | output | 1 | One-cycle pulse when a command completes |
| rd_en | output | 1 | Operand bank read enable |
| rd_addr | output | $clog2(N) | Operand word address |
| a_word | input | W | Word of a, one cycle after address |
| b_word | input | W | Word of b, one cycle after address |
| n_word | input | W | Word of n, one cycle after address |
| wr_en | output | 1 | Output bank write enable |
| wr_addr | output | $clog2(N) | Output word address |
| wr_data | output | W | Output word |

## Verification
The assertions assume that the operand banks return the word for an address exactly one cycle later. They also assume that the controller issues PICK only after DIFF and WRAP have run on the same operands, and that 0 ≤ a, b < n holds. The bench models the banks as registered-read arrays. It draws a and b by reducing random values modulo a random n of at least 2, and adds fixed corner vectors (a = b, a = 0 with b = n − 1, b = 0) so that operands never leave that range. Every command sequence is issued in the order DIFF, WRAP, PICK. The bench waits for `done` before sending the next start, except in the one deliberate test of a start sent while the block is busy.

// File: rtl/modsub_pkg.sv
package modsub_pkg;
  typedef enum logic [1:0] {
    OP_DIFF = 2'd0,
    OP_WRAP = 2'd1,
    OP_PICK = 2'd2,
    OP_NONE = 2'd3
  } msub_op_e;
endpackage

// File: rtl/modsub_sweep.sv
module modsub_sweep
  import modsub_pkg::*;
#(
  parameter int N  = 8,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  msub_op_e      op_in,
  output logic          busy,
  output msub_op_e      cur_op,
  output logic          p0_vld,
  output logic [AW-1:0] p0_addr,
  output logic          p1_vld,
  output logic          p1_first,
  output logic          p1_last,
  output logic          p3_vld,
  output logic [AW-1:0] p3_addr,
  output logic          done
);
  localparam logic [AW-1:0] LAST = AW'(N - 1);

  logic          run;
  logic [AW-1:0] idx;
  logic          v1, v2, v3;
  logic [AW-1:0] a1, a2, a3;

  assign p0_vld   = run;
  assign p0_addr  = idx;
  assign p1_vld   = v1;
  assign p1_first = (a1 == '0);
  assign p1_last  = (a1 == LAST);
  assign p3_vld   = v3;
  assign p3_addr  = a3;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      run    <= 1'b0;
      idx    <= '0;
      cur_op <= OP_DIFF;
      v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0;
      a1 <= '0;   a2 <= '0;   a3 <= '0;
      done   <= 1'b0;
    end else begin
      done <= v3 && (a3 == LAST);
      if (!busy && start && op_in != OP_NONE) begin
        busy   <= 1'b1;
        run    <= 1'b1;
        idx    <= '0;
        cur_op <= op_in;
      end else begin
        if (run) begin
          if (idx == LAST) run <= 1'b0;
          else             idx <= idx + 1'b1;
        end
        if (v3 && (a3 == LAST)) busy <= 1'b0;
      end
      v1 <= run; a1 <= idx;
      v2 <= v1;  a2 <= a1;
      v3 <= v2;  a3 <= a2;
    end
  end

  // R2: addresses advance by one within a sweep
  a_r2_addr_step: assert property (@(posedge clk) disable iff (rst)
    (run && idx != LAST) |=> (run && idx == $past(idx) + 1'b1));
  // R7: completion pulse lasts a single cycle
  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R8: the running command code cannot change mid-command
  a_r8_op_stable: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> (!busy || $stable(cur_op)));
endmodule

// File: rtl/modsub_word_alu.sv
module modsub_word_alu
  import modsub_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  msub_op_e     op,
  input  logic         p1_vld,
  input  logic         p1_first,
  input  logic         p1_last,
  input  logic [W-1:0] a_w,
  input  logic [W-1:0] b_w,
  input  logic [W-1:0] n_w,
  input  logic [W-1:0] x_w,
  input  logic [W-1:0] y_w,
  output logic [W-1:0] res_w,
  output logic         borrow
);
  logic [1:0]   cy;
  logic [1:0]   cin;
  logic [W-1:0] n_eff;
  logic [W+1:0] tot;
  logic [W-1:0] s1;

  // a + ~b + n + carry; initial carry 1 turns ~b into -b
  always_comb begin
    cin   = p1_first ? 2'd1 : cy;
    n_eff = (op == OP_WRAP) ? n_w : '0;
    tot   = {2'b00, a_w} + {2'b00, ~b_w} + {2'b00, n_eff} + (W+2)'(cin);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cy     <= '0;
      s1     <= '0;
      res_w  <= '0;
      borrow <= 1'b0;
    end else begin
      if (p1_vld) begin
        s1 <= (op == OP_PICK) ? (borrow ? y_w : x_w) : tot[W-1:0];
        cy <= tot[W+1:W];
        if (p1_last && op == OP_DIFF) borrow <= ~tot[W];
      end
      res_w <= s1;
    end
  end

  // R3: without n the word carry never reaches two
  a_r3_diff_carry: assert property (@(posedge clk) disable iff (rst)
    (p1_vld && op == OP_DIFF) |-> (tot[W+1] == 1'b0));
endmodule

// File: rtl/modsub_scratch.sv
module modsub_scratch #(
  parameter int W  = 16,
  parameter int N  = 8,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic [1:0]    we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata [2]
);
  for (genvar g = 0; g < 2; g++) begin : g_bank
    logic [W-1:0] mem [N];
    always_ff @(posedge clk) begin
      if (we[g]) mem[waddr] <= wdata;
      rdata[g] <= mem[raddr];
    end
  end
endmodule

// File: rtl/modsub_seq.sv
module modsub_seq
  import modsub_pkg::*;
#(
  parameter int W  = 16,
  parameter int N  = 8,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [1:0]    op,
  output logic          done,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [W-1:0]  a_word,
  input  logic [W-1:0]  b_word,
  input  logic [W-1:0]  n_word,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [W-1:0]  wr_data
);
  logic          busy, p0_vld, p1_vld, p1_first, p1_last, p3_vld, borrow;
  logic [AW-1:0] p0_addr, p3_addr;
  msub_op_e      cur_op;
  logic [W-1:0]  res_w;
  logic [W-1:0]  scr_q [2];
  logic [1:0]    scr_we;

  modsub_sweep #(.N(N)) u_sweep (
    .clk(clk), .rst(rst), .start(start), .op_in(msub_op_e'(op)),
    .busy(busy), .cur_op(cur_op),
    .p0_vld(p0_vld), .p0_addr(p0_addr),
    .p1_vld(p1_vld), .p1_first(p1_first), .p1_last(p1_last),
    .p3_vld(p3_vld), .p3_addr(p3_addr), .done(done)
  );

  modsub_word_alu #(.W(W)) u_alu (
    .clk(clk), .rst(rst), .op(cur_op),
    .p1_vld(p1_vld), .p1_first(p1_first), .p1_last(p1_last),
    .a_w(a_word), .b_w(b_word), .n_w(n_word),
    .x_w(scr_q[0]), .y_w(scr_q[1]),
    .res_w(res_w), .borrow(borrow)
  );

  assign scr_we[0] = p3_vld && (cur_op == OP_DIFF);
  assign scr_we[1] = p3_vld && (cur_op == OP_WRAP);

  modsub_scratch #(.W(W), .N(N)) u_scratch (
    .clk(clk), .we(scr_we), .waddr(p3_addr), .wdata(res_w),
    .raddr(p0_addr), .rdata(scr_q)
  );

  assign rd_en   = p0_vld && (cur_op != OP_PICK);
  assign rd_addr = p0_addr;
  assign wr_en   = p3_vld && (cur_op == OP_PICK);
  assign wr_addr = p3_addr;
  assign wr_data = res_w;

  // R3 R4: output bank is written only by the selecting pass
  a_r3_write_only_pick: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (busy && cur_op == OP_PICK));
  // R10: kept borrow changes only while a DIFF pass runs
  a_r10_borrow_hold: assert property (@(posedge clk) disable iff (rst)
    !(busy && cur_op == OP_DIFF) |=> $stable(borrow));
endmodule

// File: tb/modsub_seq_tb_top.sv
module modsub_seq_tb_top;
  localparam int W  = 16;
  localparam int N  = 8;
  localparam int AW = $clog2(N);
  localparam int WN = W * N;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [1:0]    op = 2'd0;
  logic          done, rd_en, wr_en;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [W-1:0]  a_word, b_word, n_word, wr_data;

  always #10 clk = ~clk;

  modsub_seq #(.W(W), .N(N)) dut_i (
    .clk(clk), .rst(rst), .start(start), .op(op), .done(done),
    .rd_en(rd_en), .rd_addr(rd_addr),
    .a_word(a_word), .b_word(b_word), .n_word(n_word),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  // operand bank model: registered read
  logic [W-1:0] a_bank [N];
  logic [W-1:0] b_bank [N];
  logic [W-1:0] n_bank [N];
  always @(posedge clk) begin
    a_word <= a_bank[rd_addr];
    b_word <= b_bank[rd_addr];
    n_word <= n_bank[rd_addr];
  end

  int errors = 0, checks = 0;
  int cyc = 0;
  int done_cnt = 0, rd_cnt = 0, wr_cnt = 0;
  int last_wr_cyc = -10, first_wr_cyc = -1;
  logic [AW-1:0] exp_rd = '0;
  logic [AW+W-1:0] sb_q [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (rd_en) begin
        rd_cnt++;
        check(rd_addr == exp_rd, "R2", "read address order", rd_addr, exp_rd);
        exp_rd = (rd_addr == AW'(N-1)) ? '0 : rd_addr + 1'b1;
      end
      if (wr_en) begin
        wr_cnt++;
        if (first_wr_cyc < 0) first_wr_cyc = cyc;
        last_wr_cyc = cyc;
        if (sb_q.size() == 0) begin
          check(1'b0, "R3", "unexpected output write", wr_data, 0);
        end else begin
          logic [AW+W-1:0] e;
          e = sb_q.pop_front();
          check({wr_addr, wr_data} == e, "R5", "output word {addr,data}",
                {wr_addr, wr_data}, e);
        end
      end
      if (done) begin
        done_cnt++;
        check(last_wr_cyc == cyc - 1 || last_wr_cyc < 0 || wr_cnt == 0 ||
              last_wr_cyc < cyc - N - 4,
              "R7", "done one cycle after last write", cyc, last_wr_cyc + 1);
      end
    end
  end

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    finish_up();
  end

  task automatic load(input logic [WN-1:0] a, input logic [WN-1:0] b,
                      input logic [WN-1:0] n);
    for (int i = 0; i < N; i++) begin
      a_bank[i] = a[i*W +: W];
      b_bank[i] = b[i*W +: W];
      n_bank[i] = n[i*W +: W];
    end
  endtask

  task automatic push_expected(input logic [WN-1:0] r);
    for (int i = 0; i < N; i++) sb_q.push_back({AW'(i), r[i*W +: W]});
  endtask

  task automatic run_op(input logic [1:0] code, input string req);
    int d0, r0, s_cyc, guard;
    @(negedge clk);
    d0 = done_cnt; r0 = rd_cnt; s_cyc = cyc;
    first_wr_cyc = -1;
    start = 1'b1; op = code;
    @(negedge clk);
    start = 1'b0;
    guard = 0;
    while (done_cnt == d0 && guard < 100) begin @(negedge clk); guard++; end
    check(done_cnt == d0 + 1, req, "done count", done_cnt - d0, 1);
    check(rd_cnt - r0 == ((code == 2'd2) ? 0 : N), "R2", "read cycles",
          rd_cnt - r0, (code == 2'd2) ? 0 : N);
    if (code == 2'd2) begin
      check(first_wr_cyc - s_cyc == 4, "R6", "first write latency",
            first_wr_cyc - s_cyc, 4);
      check(sb_q.size() == 0, "R5", "all words written", sb_q.size(), 0);
    end
  endtask

  task automatic full_case(input logic [WN-1:0] a, input logic [WN-1:0] b,
                           input logic [WN-1:0] n, input string req);
    logic [WN-1:0] r;
    r = (a >= b) ? a - b : a - b + n;
    load(a, b, n);
    run_op(2'd0, "R3");
    run_op(2'd1, "R4");
    push_expected(r);
    run_op(2'd2, req);
  endtask

  function automatic logic [WN-1:0] rnd();
    logic [WN-1:0] v;
    for (int i = 0; i < WN / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  initial begin
    logic [WN-1:0] a, b, n;
    for (int i = 0; i < N; i++) begin a_bank[i] = '0; b_bank[i] = '0; n_bank[i] = '0; end
    repeat (3) @(negedge clk);
    check(!done && !rd_en && !wr_en, "R1", "outputs during reset",
          {done, rd_en, wr_en}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!done && !rd_en && !wr_en, "R1", "outputs after reset",
          {done, rd_en, wr_en}, 0);

    // random operands, both orderings
    for (int k = 0; k < 8; k++) begin
      n = rnd() | 2; a = rnd() % n; b = rnd() % n;
      full_case(a, b, n, "R5");
    end
    n = rnd() | 2;
    a = rnd() % n; full_case(a, a, n, "R5");            // a = b
    full_case('0, n - 1, n, "R5");                      // a < b, result 1
    full_case(n - 1, '0, n, "R5");                      // b = 0
    a = (rnd() % n) | 1; full_case(a - 1, a, n, "R3");  // borrow set, result n-1

    // R10: borrow kept; repeat PICK gives same result
    push_expected(a - 1 - a + n);
    run_op(2'd2, "R10");

    // R9: op 3 ignored
    begin
      int d0, r0, w0;
      @(negedge clk);
      d0 = done_cnt; r0 = rd_cnt; w0 = wr_cnt;
      start = 1'b1; op = 2'd3;
      @(negedge clk); start = 1'b0;
      repeat (N + 10) @(negedge clk);
      check(done_cnt == d0 && rd_cnt == r0 && wr_cnt == w0, "R9",
            "no activity for op 3", done_cnt - d0 + rd_cnt - r0, 0);
    end

    // R8: start during busy DIFF is ignored
    begin
      int d0;
      logic [WN-1:0] r;
      n = rnd() | 2; a = rnd() % n; b = rnd() % n;
      r = (a >= b) ? a - b : a - b + n;
      load(a, b, n);
      @(negedge clk);
      d0 = done_cnt;
      start = 1'b1; op = 2'd0;
      @(negedge clk); start = 1'b0;
      repeat (2) @(negedge clk);
      start = 1'b1; op = 2'd2;
      @(negedge clk); start = 1'b0;
      repeat (N + 12) @(negedge clk);
      check(done_cnt == d0 + 1, "R8", "single done for busy start",
            done_cnt - d0, 1);
      run_op(2'd1, "R8");
      push_expected(r);
      run_op(2'd2, "R8");
    end

    repeat (4) @(negedge clk);
    finish_up();
  end
endmodule